// File: doc/BRIEF.md
# Active Tamper Mesh Sequence Monitor

This block protects a security die by driving a keyed pseudo-random bit stream onto several mesh conductors and watching what comes back at the far end of each one. A 31-bit linear feedback shift register, loaded from a device-unique secret, produces the stream. Each conductor carries its own phase of it. The returned bit of every line is synchronised and compared with the bit that was driven a calibrated number of cycles earlier. That lag must fall inside a configurable cycle window. Ordinary routing skew is absorbed this way, while a repeater or replay bridge that adds latency lands on the wrong bit and mismatches.

Any mismatch, or any line whose calibrated lag lies outside the window, sets a sticky per-line fault bit, a tamper flag and a zeroize request. Only a full reset clears them. A seed reload or a change of window or lag leaves them set. Checking is held off for a short time after reset and after each seed load, so the synchroniser and history can fill without a false alarm.

Top module: `tamper_mesh_monitor`

## Requirements
- R1: The generator state is 31 bits and follows x^31 + x^28 + 1 in Fibonacci form. Each cycle the state shifts one place toward the MSB, and the new bit 0 is state[30] XOR state[27]. A seed presented with the load strobe at a clock edge becomes the state at that edge. Drive outputs register state taps, so one edge later they show the seed's tap bits.
- R2: A load of an all-zero seed, and reset itself, set the state to 31'h6F708192 instead, so the generator never locks up.
- R3: Mesh line i is driven from state bit 7*i (bits 0, 7, 14, 21 for four lines). Because of this, a short that feeds one line's drive into a neighbour's sense input raises an alarm.
- R4: Each sense input passes through two flops. The calibrated lag L of a line counts from the drive register output to the synchronised sample, so a direct loopback has L = 2 and an external delay of D cycles has L = D + 2. A clean loopback configured that way, with L not above the window, never raises an alarm.
- R5: When a synchronised sample differs from the drive bit L cycles earlier while checking is enabled, that line's fault bit, the tamper flag and the zeroize request are all set at the same edge. This is the third clock edge after the faulty sense value is first presented, which is within window + 3 cycles.
- R6: A line whose lag is 0, or is larger than the effective window, is flagged as faulty once checking is enabled. The effective window is the configured window limited to a maximum of 8.
- R7: Fault bits, the tamper flag and the zeroize request are sticky. Seed loads and changes to window or lag do not clear them. Reset clears all of them, and also clears every drive output.
- R8: Checking is disabled for the 10 edges after reset and for window + 2 edges after a seed load. The edge at which the load strobe is sampled is itself never checked. A violation that persists is therefore flagged at the 11th edge after reset and at the 8th edge counted from the load edge when the window is 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Mesh clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_i | input | 31 | Secret seed for the generator |
| seed_load_i | input | 1 | Load strobe for seed_i |
| win_cfg_i | input | 4 | Allowed lag window in cycles (limited to 8) |
| lag_cfg_i | input | 16 | Per-line calibrated lag, 4 bits per line, line 0 in the low bits |
| mesh_drv_o | output | 4 | Drive ends of the mesh lines |
| mesh_sns_i | input | 4 | Return ends of the mesh lines (asynchronous) |
| line_fault_o | output | 4 | Sticky per-line fault status |
| tamper_o | output | 1 | Sticky tamper flag |
| zeroize_o | output | 1 | Sticky zeroize request |

## Verification
The drive outputs are due one edge after the generator state they reflect. The bench keeps its own generator model, advanced on the same edges, and compares the drive outputs with it at every falling edge. An alarm is due exactly three edges after a corrupted sense value appears, so the directed inversion case samples at two edges (still clear) and three edges (set). The masking cases sample at the last masked edge and the first checked one: the 10th and 11th edges after reset, and the 7th and 8th counted from a load edge with a window of 4. The random cases compare every fault bit and the tamper flag each cycle with a reference computed from the loopback delays the bench itself inserts.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  // Fallback generator state used at reset and in place of an all-zero seed.
  localparam logic [63:0] SAFE_STATE = 64'h2B3C_4D5E_6F70_8192;

  // Bit of the generator state that feeds a given mesh line.
  function automatic int unsigned line_tap(input int unsigned line, input int unsigned stride);
    return line * stride;
  endfunction
endpackage

// File: rtl/tmm_lfsr.sv
module tmm_lfsr import tmm_pkg::*; #(
  parameter int W      = 31,
  parameter int TAP_HI = 31,
  parameter int TAP_LO = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] FALLBACK = SAFE_STATE[W-1:0];

  logic fb;
  assign fb = state[TAP_HI-1] ^ state[TAP_LO-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FALLBACK;
    end else if (load) begin
      state <= (seed == '0) ? FALLBACK : seed;
    end else begin
      state <= {state[W-2:0], fb};
    end
  end
endmodule

// File: rtl/tmm_mask.sv
module tmm_mask #(
  parameter int MAX_WIN = 8,
  parameter int WIN_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIN_W-1:0] win_eff,
  output logic             check_en
);
  localparam int CW = $clog2(MAX_WIN + 3);

  logic [CW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= CW'(MAX_WIN + 2);
    end else if (load) begin
      hold_q <= CW'(win_eff) + CW'(2);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - CW'(1);
    end
  end

  assign check_en = (hold_q == '0) && !load;
endmodule

// File: rtl/tmm_line.sv
module tmm_line #(
  parameter int MAX_WIN = 8,
  parameter int WIN_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tap_bit,
  input  logic             sense_i,
  input  logic [WIN_W-1:0] lag_i,
  input  logic [WIN_W-1:0] win_eff,
  input  logic             check_en,
  output logic             drive_o,
  output logic             hit_o,
  output logic             fault_o
);
  logic               sync1_q, sync2_q;
  logic [MAX_WIN-1:0] hist_q;
  logic               exp_bit;
  logic               lag_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o <= 1'b0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= '0;
    end else begin
      drive_o <= tap_bit;
      sync1_q <= sense_i;
      sync2_q <= sync1_q;
      hist_q  <= {hist_q[MAX_WIN-2:0], drive_o};
    end
  end

  // hist_q[j] holds the drive value of j+1 cycles ago
  always_comb begin
    exp_bit = 1'b0;
    for (int j = 0; j < MAX_WIN; j++) begin
      if (lag_i == WIN_W'(j + 1)) exp_bit = hist_q[j];
    end
  end

  assign lag_ok = (lag_i != '0) && (lag_i <= win_eff);
  assign hit_o  = check_en && (!lag_ok || (sync2_q != exp_bit));

  always_ff @(posedge clk) begin
    if (rst) fault_o <= 1'b0;
    else     fault_o <= fault_o | hit_o;
  end
endmodule

// File: rtl/tamper_mesh_monitor.sv
module tamper_mesh_monitor import tmm_pkg::*; #(
  parameter int NUM_LINES  = 4,
  parameter int LFSR_W     = 31,
  parameter int TAP_HI     = 31,
  parameter int TAP_LO     = 28,
  parameter int TAP_STRIDE = 7,
  parameter int MAX_WIN    = 8,
  localparam int WIN_W     = $clog2(MAX_WIN + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LFSR_W-1:0]          seed_i,
  input  logic                       seed_load_i,
  input  logic [WIN_W-1:0]           win_cfg_i,
  input  logic [NUM_LINES*WIN_W-1:0] lag_cfg_i,
  output logic [NUM_LINES-1:0]       mesh_drv_o,
  input  logic [NUM_LINES-1:0]       mesh_sns_i,
  output logic [NUM_LINES-1:0]       line_fault_o,
  output logic                       tamper_o,
  output logic                       zeroize_o
);
  generate
    if (TAP_STRIDE * (NUM_LINES - 1) >= LFSR_W) begin : g_bad_stride
      $error("line taps exceed generator width");
    end
  endgenerate

  logic [LFSR_W-1:0]    lfsr_q;
  logic [WIN_W-1:0]     win_eff;
  logic                 check_en;
  logic [NUM_LINES-1:0] hit;

  assign win_eff = (win_cfg_i > WIN_W'(MAX_WIN)) ? WIN_W'(MAX_WIN) : win_cfg_i;

  tmm_lfsr #(.W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (seed_load_i),
    .seed  (seed_i),
    .state (lfsr_q)
  );

  tmm_mask #(.MAX_WIN(MAX_WIN), .WIN_W(WIN_W)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .load     (seed_load_i),
    .win_eff  (win_eff),
    .check_en (check_en)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    tmm_line #(.MAX_WIN(MAX_WIN), .WIN_W(WIN_W)) u_line (
      .clk      (clk),
      .rst      (rst),
      .tap_bit  (lfsr_q[line_tap(i, TAP_STRIDE)]),
      .sense_i  (mesh_sns_i[i]),
      .lag_i    (lag_cfg_i[i*WIN_W +: WIN_W]),
      .win_eff  (win_eff),
      .check_en (check_en),
      .drive_o  (mesh_drv_o[i]),
      .hit_o    (hit[i]),
      .fault_o  (line_fault_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tamper_o  <= 1'b0;
      zeroize_o <= 1'b0;
    end else begin
      tamper_o  <= tamper_o  | (|hit);
      zeroize_o <= zeroize_o | (|hit);
    end
  end
endmodule

// File: rtl/tmm_sva.sv
module tmm_sva #(
  parameter int NUM_LINES = 4,
  parameter int LFSR_W    = 31
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 seed_load_i,
  input logic [LFSR_W-1:0]    lfsr_state,
  input logic [NUM_LINES-1:0] line_fault_o,
  input logic                 tamper_o,
  input logic                 zeroize_o
);
  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  a_r7_tamper_sticky: assert property (@(posedge clk) disable iff (rst)
    tamper_o |=> tamper_o);

  a_r7_faults_sticky: assert property (@(posedge clk) disable iff (rst)
    (|line_fault_o) |=> ((line_fault_o & $past(line_fault_o)) == $past(line_fault_o)));

  a_r5_alarm_has_line: assert property (@(posedge clk) disable iff (rst)
    (tamper_o || zeroize_o) |-> (|line_fault_o));

  a_r5_zeroize_with_tamper: assert property (@(posedge clk) disable iff (rst)
    $rose(tamper_o) |-> $rose(zeroize_o));

  a_r8_load_edge_unchecked: assert property (@(posedge clk) disable iff (rst)
    (seed_load_i && !tamper_o) |=> !tamper_o);
endmodule

bind tamper_mesh_monitor tmm_sva #(.NUM_LINES(NUM_LINES), .LFSR_W(LFSR_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .seed_load_i  (seed_load_i),
  .lfsr_state   (lfsr_q),
  .line_fault_o (line_fault_o),
  .tamper_o     (tamper_o),
  .zeroize_o    (zeroize_o)
);

// File: tb/tb_tamper_mesh_monitor.sv
`timescale 1ns/1ps
module tb_tamper_mesh_monitor;
  localparam int NL = 4;
  localparam int SW = 31;
  localparam int WW = 4;
  localparam logic [SW-1:0] DEF_STATE = 31'h6F708192;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] seed_i = '0;
  logic          seed_load_i = 1'b0;
  logic [WW-1:0] win_cfg_i = 4'd4;
  logic [NL*WW-1:0] lag_cfg_i = '0;
  logic [NL-1:0] mesh_drv_o, mesh_sns_i, line_fault_o;
  logic          tamper_o, zeroize_o;

  int n_chk = 0;
  int n_err = 0;

  // bench-side fault injection: 0 clean, 1 stuck0, 2 stuck1, 3 invert, 4 extra delay, 5 short to next line
  int mode [NL];
  int dly  [NL];
  int extra[NL];
  logic [15:0] dl [NL];

  always #4 clk = ~clk;

  tamper_mesh_monitor dut (
    .clk(clk), .rst(rst), .seed_i(seed_i), .seed_load_i(seed_load_i),
    .win_cfg_i(win_cfg_i), .lag_cfg_i(lag_cfg_i), .mesh_drv_o(mesh_drv_o),
    .mesh_sns_i(mesh_sns_i), .line_fault_o(line_fault_o),
    .tamper_o(tamper_o), .zeroize_o(zeroize_o)
  );

  function automatic logic [SW-1:0] step(input logic [SW-1:0] s);
    return {s[SW-2:0], s[30] ^ s[27]};
  endfunction

  function automatic logic [NL-1:0] taps(input logic [SW-1:0] s);
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) r[i] = s[7*i];
    return r;
  endfunction

  function automatic logic delayed(input int ln, input int d);
    return (d == 0) ? mesh_drv_o[ln] : dl[ln][d-1];
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < NL; i++) dl[i] <= {dl[i][14:0], mesh_drv_o[i]};
  end

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      case (mode[i])
        1:       mesh_sns_i[i] = 1'b0;
        2:       mesh_sns_i[i] = 1'b1;
        3:       mesh_sns_i[i] = ~delayed(i, dly[i]);
        4:       mesh_sns_i[i] = delayed(i, dly[i] + extra[i]);
        5:       mesh_sns_i[i] = delayed((i + 1) % NL, dly[i]);
        default: mesh_sns_i[i] = delayed(i, dly[i]);
      endcase
    end
  end

  // reference model built from the requirements
  logic [SW-1:0] m_lfsr;
  logic [NL-1:0] m_drv, m_s1, m_s2, m_fault;
  logic [7:0]    m_hist [NL];
  int            m_cnt;
  logic          m_tamp;

  always @(posedge clk) begin
    int weff;
    logic any;
    weff = (win_cfg_i > 8) ? 8 : int'(win_cfg_i);
    if (rst) begin
      m_lfsr <= DEF_STATE; m_drv <= '0; m_s1 <= '0; m_s2 <= '0;
      m_fault <= '0; m_tamp <= 1'b0; m_cnt <= 10;
      for (int i = 0; i < NL; i++) m_hist[i] <= '0;
    end else begin
      any = 1'b0;
      for (int i = 0; i < NL; i++) begin
        int lg;
        logic bad;
        lg  = int'(lag_cfg_i[i*WW +: WW]);
        bad = (lg == 0) || (lg > weff) || (m_s2[i] != m_hist[i][lg-1]);
        if (m_cnt == 0 && !seed_load_i && bad) begin
          m_fault[i] <= 1'b1; any = 1'b1;
        end
        m_hist[i] <= {m_hist[i][6:0], m_drv[i]};
      end
      if (any) m_tamp <= 1'b1;
      m_drv <= taps(m_lfsr);
      m_s1  <= mesh_sns_i;
      m_s2  <= m_s1;
      if (seed_load_i) begin
        m_lfsr <= (seed_i == '0) ? DEF_STATE : seed_i;
        m_cnt  <= weff + 2;
      end else begin
        m_lfsr <= step(m_lfsr);
        if (m_cnt != 0) m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      if (!rst) begin
        chk(mesh_drv_o == m_drv, "R1 drive stream", 64'(mesh_drv_o), 64'(m_drv));
        chk(line_fault_o == m_fault, "R4 line faults", 64'(line_fault_o), 64'(m_fault));
        chk(tamper_o == m_tamp && zeroize_o == m_tamp, "R5 tamper/zeroize",
            64'({tamper_o, zeroize_o}), 64'({m_tamp, m_tamp}));
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < NL; i++) begin mode[i] = 0; extra[i] = 0; end
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clean_setup(input logic [SW-1:0] sd);
    for (int i = 0; i < NL; i++) begin
      dly[i] = $urandom_range(0, 3);
      mode[i] = 0;
      lag_cfg_i[i*WW +: WW] = WW'(dly[i] + 2);
    end
    win_cfg_i   = WW'($urandom_range(5, 8));
    seed_i      = sd;
    seed_load_i = 1'b1;
    cyc(1);
    seed_load_i = 1'b0;
  endtask

  task automatic run_tests();
    logic [SW-1:0] s;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) begin mode[i] = 0; dly[i] = 0; extra[i] = 0; end

    // reset state and mask after reset with all lags invalid (lag 0)
    repeat (3) @(negedge clk);
    chk(mesh_drv_o == '0 && line_fault_o == '0 && !tamper_o && !zeroize_o, "R7 reset state",
        64'({mesh_drv_o, line_fault_o, tamper_o, zeroize_o}), 64'h0);
    rst = 1'b0;
    cyc(10);
    chk(!tamper_o, "R8 masked 10 edges after reset", 64'(tamper_o), 64'h0);
    cyc(1);
    chk(tamper_o && line_fault_o == 4'hF, "R6 lag zero flagged at edge 11",
        64'({tamper_o, line_fault_o}), 64'h1F);

    // generator stepping and per-line taps after a nonzero seed
    do_reset();
    s = 31'h1234_5678;
    for (int i = 0; i < NL; i++) lag_cfg_i[i*WW +: WW] = WW'(2);
    win_cfg_i = 4'd4; seed_i = s; seed_load_i = 1'b1;
    cyc(1); seed_load_i = 1'b0;
    cyc(1);
    chk(mesh_drv_o == taps(s), "R3 taps of seed", 64'(mesh_drv_o), 64'(taps(s)));
    cyc(1);
    chk(mesh_drv_o == taps(step(s)), "R1 one step", 64'(mesh_drv_o), 64'(taps(step(s))));

    // zero seed falls back
    seed_i = '0; seed_load_i = 1'b1;
    cyc(1); seed_load_i = 1'b0;
    cyc(1);
    chk(mesh_drv_o == taps(DEF_STATE), "R2 zero seed fallback", 64'(mesh_drv_o), 64'(taps(DEF_STATE)));
    cyc(40);
    chk(!tamper_o, "R4 direct loopback quiet", 64'(tamper_o), 64'h0);

    // clean loopback with skew
    do_reset();
    clean_setup(31'($urandom()));
    cyc(200);
    chk(!tamper_o && line_fault_o == '0, "R4 skewed loopback quiet", 64'(line_fault_o), 64'h0);

    // inverted line: exact latency, then stickiness
    mode[1] = 3;
    cyc(2);
    chk(!tamper_o, "R5 not yet at edge 2", 64'(tamper_o), 64'h0);
    cyc(1);
    chk(tamper_o && zeroize_o && line_fault_o == 4'b0010, "R5 inversion at edge 3",
        64'({tamper_o, zeroize_o, line_fault_o}), 64'h32);
    mode[1] = 0;
    clean_setup(31'($urandom()));
    win_cfg_i = 4'd8;
    cyc(6);
    chk(tamper_o && zeroize_o && line_fault_o == 4'b0010, "R7 sticky after reload/config",
        64'({tamper_o, zeroize_o, line_fault_o}), 64'h32);

    // stuck-at, extra delay, short
    for (int k = 0; k < 4; k++) begin
      do_reset();
      clean_setup(31'($urandom()));
      cyc(20);
      case (k)
        0: mode[2] = 1;
        1: mode[0] = 2;
        2: begin mode[3] = 4; extra[3] = int'(win_cfg_i) + 1; end
        default: mode[0] = 5;
      endcase
      cyc(60);
      if (k == 3) chk(tamper_o, "R3 short between lines", 64'(tamper_o), 64'h1);
      else        chk(tamper_o, "R5 stuck or late line", 64'(tamper_o), 64'h1);
    end

    // mask after load: window 4, lag made invalid on the load edge
    do_reset();
    for (int i = 0; i < NL; i++) begin dly[i] = 0; lag_cfg_i[i*WW +: WW] = WW'(2); end
    win_cfg_i = 4'd4;
    cyc(15);
    seed_i = 31'($urandom()); seed_load_i = 1'b1;
    lag_cfg_i[0 +: WW] = WW'(5);
    cyc(1); seed_load_i = 1'b0;
    cyc(6);
    chk(!tamper_o, "R8 masked through 7th edge after load", 64'(tamper_o), 64'h0);
    cyc(1);
    chk(tamper_o && line_fault_o == 4'b0001, "R6 lag above window flagged",
        64'({tamper_o, line_fault_o}), 64'h11);

    // window clamp: 15 acts as 8
    do_reset();
    for (int i = 0; i < NL; i++) begin dly[i] = 6; lag_cfg_i[i*WW +: WW] = WW'(8); end
    win_cfg_i = 4'd15;
    cyc(40);
    chk(!tamper_o, "R6 lag 8 inside clamped window", 64'(tamper_o), 64'h0);
    lag_cfg_i[2*WW +: WW] = WW'(9);
    cyc(2);
    chk(line_fault_o == 4'b0100, "R6 lag 9 beyond clamp", 64'(line_fault_o), 64'h4);

    // random mix
    for (int it = 0; it < 12; it++) begin
      int ln, md;
      do_reset();
      clean_setup(31'($urandom()));
      cyc(25);
      ln = $urandom_range(0, NL-1);
      md = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 5);
      mode[ln] = md;
      extra[ln] = $urandom_range(1, 3) + int'(win_cfg_i);
      cyc(60);
      chk(tamper_o == (md != 0), "R5 random case alarm", 64'(tamper_o), 64'(md != 0));
    end
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R5 watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule